// File: doc/BRIEF.md
# Receive Volume Attenuator

This block scales each incoming 13-bit two's-complement voice sample by one of eight fixed gains. The gain is chosen by a 3-bit code that travels in the same data word as the sample. It sits in a voice receive path between the serial word unpacker and the interpolation filter. Every valid word carries its own code. The block keeps no volume setting from one word to the next, so a change of code takes effect on the very sample it arrives with.

The gains fall in 3 dB steps. Code 0 passes the sample through unchanged, and code 7 attenuates it by 21 dB. Each gain is a fixed-point constant multiplied in by a network of shifted partial sums, with one such network per code; no general multiplier is used. The product is rounded symmetrically about zero, and the result is registered one clock after the valid strobe.

Top module: `rx_vol_atten`

## Requirements
- R1: `valid_o` is high in exactly the cycle that follows a cycle in which `valid_i` was high at the clock edge, and low otherwise.
- R2: With code 0, the registered output equals the input sample exactly, including -4096 and +4095, with no overflow.
- R3: Code k (bit 2 is the most significant and is the first bit received) applies a gain of 10^(-3k/20). The output is within one LSB of the real-valued product of the sample and that gain.
- R4: Rounding is symmetric. For any sample x other than -4096 and any code, the output for -x is the exact negation of the output for x.
- R5: Each sample uses only the code presented with it. Back-to-back samples with different codes are each scaled by their own code.
- R6: While `valid_i` is low, `sample_o` holds its last value whatever `sample_i` and `code_i` do.
- R7: While `rst_ni` is low, `valid_o` and `sample_o` are zero.
- R8: The output magnitude never exceeds the input magnitude. A nonzero output has the same sign as the input.
- R9: A zero input sample gives a zero output for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Sample and code are present this cycle |
| sample_i | input | 13 | Two's-complement sample; bit 12 is the sign |
| code_i | input | 3 | Attenuation code, 3 dB per step |
| valid_o | output | 1 | Output sample is new this cycle |
| sample_o | output | 13 | Attenuated two's-complement sample |

## Verification
The assertions take for granted that `sample_i` and `code_i` are settled at every clock edge where `valid_i` is high. They also assume that nothing is presented during the first cycle after reset is released, because some checks compare against the previous cycle's inputs. The stimulus changes inputs only on the falling clock edge and raises `valid_i` only after reset has been released. Between bursts, it deliberately drives random samples and codes while `valid_i` is low, so that the holding behaviour is exercised.

// File: rtl/vol_pkg.sv
package vol_pkg;
  localparam int SAMPLE_W = 13;
  localparam int CODE_W   = 3;
  localparam int LEVELS   = 1 << CODE_W;
  localparam int FRAC_W   = 16;
  localparam int COEF_W   = FRAC_W + 1;
  localparam int PROD_W   = SAMPLE_W + COEF_W;

  // round(10^(-3k/20) * 2^16), each within 0.01 dB of the nominal step
  function automatic int unsigned step_coef(input int k);
    case (k)
      0:       return 65536;
      1:       return 46396;
      2:       return 32846;
      3:       return 23253;
      4:       return 16462;
      5:       return 11654;
      6:       return 8250;
      7:       return 5841;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/vol_const_mul.sv
module vol_const_mul #(
  parameter int          MAG_W  = 13,
  parameter int          COEF_W = 17,
  parameter int unsigned COEF   = 0,
  localparam int         PROD_W = MAG_W + COEF_W
) (
  input  logic [MAG_W-1:0]  mag_i,
  output logic [PROD_W-1:0] prod_o
);
  localparam logic [COEF_W-1:0] C = COEF_W'(COEF);

  logic [PROD_W-1:0] pp [COEF_W];

  for (genvar b = 0; b < COEF_W; b++) begin : g_pp
    if (C[b]) begin : g_on
      assign pp[b] = PROD_W'(mag_i) << b;
    end else begin : g_off
      assign pp[b] = '0;
    end
  end

  always_comb begin
    prod_o = '0;
    for (int b = 0; b < COEF_W; b++) prod_o = prod_o + pp[b];
  end
endmodule

// File: rtl/vol_round.sv
module vol_round #(
  parameter int PROD_W   = 30,
  parameter int FRAC_W   = 16,
  parameter int SAMPLE_W = 13
) (
  input  logic                neg_i,
  input  logic [PROD_W-1:0]   prod_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

  logic [PROD_W-1:0]   biased;
  logic [SAMPLE_W-1:0] mag;

  // round half away from zero on the magnitude, then restore the sign
  assign biased   = prod_i + HALF;
  assign mag      = biased[FRAC_W +: SAMPLE_W];
  assign sample_o = neg_i ? SAMPLE_W'(-mag) : mag;
endmodule

// File: rtl/rx_vol_atten.sv
module rx_vol_atten
  import vol_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [CODE_W-1:0]   code_i,
  output logic                valid_o,
  output logic [SAMPLE_W-1:0] sample_o
);
  logic                neg;
  logic [SAMPLE_W-1:0] mag;
  logic [PROD_W-1:0]   prod [LEVELS];
  logic [SAMPLE_W-1:0] scaled;

  assign neg = sample_i[SAMPLE_W-1];
  // -(-4096) is 4096, which still fits as an unsigned 13-bit magnitude
  assign mag = neg ? SAMPLE_W'(-sample_i) : sample_i;

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    vol_const_mul #(
      .MAG_W (SAMPLE_W),
      .COEF_W(COEF_W),
      .COEF  (step_coef(k))
    ) i_mul (
      .mag_i (mag),
      .prod_o(prod[k])
    );
  end

  vol_round #(
    .PROD_W  (PROD_W),
    .FRAC_W  (FRAC_W),
    .SAMPLE_W(SAMPLE_W)
  ) i_round (
    .neg_i   (neg),
    .prod_i  (prod[code_i]),
    .sample_o(scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) sample_o <= scaled;
    end
  end
endmodule

// File: rtl/vol_atten_chk.sv
module vol_atten_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [12:0] sample_i,
  input logic [2:0]  code_i,
  input logic        valid_o,
  input logic [12:0] sample_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  function automatic logic [13:0] mag_of(input logic [12:0] v);
    return v[12] ? 14'(-{v[12], v}) : {1'b0, v};
  endfunction

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> valid_o == $past(valid_i));

  a_r2_unity_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) && $past(code_i) == 3'd0 |-> sample_o == $past(sample_i));

  a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(valid_i) |-> $stable(sample_o));

  a_r8_no_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) |-> mag_of(sample_o) <= mag_of($past(sample_i)));

  a_r8_sign_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) && sample_o != '0 |-> sample_o[12] == $past(sample_i[12]));

  a_r9_zero_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(valid_i) && $past(sample_i) == '0 |-> sample_o == '0);

  always @(negedge clk_i) begin
    if (!rst_ni) a_r7_reset_idle: assert (valid_o == 1'b0 && sample_o == '0);
  end
endmodule

bind rx_vol_atten vol_atten_chk i_vol_atten_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sample_i(sample_i),
  .code_i  (code_i),
  .valid_o (valid_o),
  .sample_o(sample_o)
);

// File: tb/test_rx_vol_atten.sv
module test_rx_vol_atten;
  logic        clk_i   = 1'b0;
  logic        rst_ni  = 1'b0;
  logic        valid_i = 1'b0;
  logic [12:0] sample_i = '0;
  logic [2:0]  code_i   = '0;
  logic        valid_o;
  logic [12:0] sample_o;

  typedef struct {int x; int code;} item_t;
  item_t exp_q[$];
  int    out_log[$];
  int    total = 0;
  int    bad = 0;
  bit    exp_valid = 1'b0;
  int    last_out = 0;
  bit    done = 1'b0;

  rx_vol_atten i_rx_vol_atten (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .sample_i(sample_i),
    .code_i(code_i), .valid_o(valid_o), .sample_o(sample_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic drive(input int x, input int code);
    @(negedge clk_i);
    sample_i = 13'(x);
    code_i   = 3'(code);
    valid_i  = 1'b1;
    exp_q.push_back('{x, code});
  endtask

  // R6: junk on data and code while not valid
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      valid_i  = 1'b0;
      sample_i = 13'($urandom);
      code_i   = 3'($urandom);
    end
  endtask

  always @(posedge clk_i) exp_valid <= rst_ni && valid_i;

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      int out;
      out = int'($signed(sample_o));
      check(valid_o == exp_valid, "R1 valid_o", valid_o, exp_valid);
      if (valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected output", out, 0);
        end else begin
          item_t it;
          real   r;
          real   d;
          it = exp_q.pop_front();
          r  = it.x * $pow(10.0, -3.0 * it.code / 20.0);
          d  = out - r;
          check(d <= 1.0 && d >= -1.0, "R3 gain", out, $rtoi(r));
          if (it.code == 0) check(out == it.x, "R2 unity", out, it.x);
          if (it.x == 0) check(out == 0, "R9 zero", out, 0);
          check(iabs(out) <= iabs(it.x) && (out == 0 || (out < 0) == (it.x < 0)),
                "R8 magnitude/sign", out, it.x);
          out_log.push_back(out);
          last_out = out;
        end
      end else begin
        check(out == last_out, "R6 hold", out, last_out);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[14] = '{0, 1, -1, 2, -2, 3, 5, 4095, -4096, -4095, 1000, -1000, 2047, -2048};
    int base;
    int npairs;

    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && sample_o == '0, "R7 reset", int'(sample_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(2);

    // R3 R2 R9: sweep every code over edge values
    for (int c = 0; c < 8; c++) begin
      foreach (vals[i]) drive(vals[i], c);
      idle(3);
    end

    // R5: code changes every word, back to back
    for (int i = 0; i < 16; i++) drive((i % 2) ? -3000 : 3000, i % 8);
    idle(3);

    // random traffic with gaps
    for (int i = 0; i < 300; i++) begin
      drive(int'($signed(13'($urandom))), int'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
    end
    idle(4);

    // R4: symmetric pairs
    base = out_log.size();
    npairs = 24;
    for (int j = 0; j < npairs; j++) begin
      int v;
      v = int'($urandom_range(1, 4095));
      drive(v, j % 8);
      drive(-v, j % 8);
    end
    idle(4);
    for (int j = 0; j < npairs; j++)
      check(out_log[base + 2*j] == -out_log[base + 2*j + 1], "R4 symmetric",
            out_log[base + 2*j + 1], -out_log[base + 2*j]);

    done = 1'b1;
    check(exp_q.size() == 0, "R1 drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule